// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the system reset for a processor subsystem. It merges four reset causes into one: a synchronous flag saying the supply is below its threshold, an active-low manual reset request, an active-low auxiliary reset request, and a watchdog that expects regular activity on a strobe input. While any cause is active the reset is held. Once the last cause goes away the reset is extended for a fixed number of clock cycles before it is released.

The manual and auxiliary requests and the strobe come from outside the clock domain. Each one passes through a two-stage synchronizer. The manual request then goes through a glitch filter that drops short pulses. The watchdog counts up while the strobe stays at one level and restarts on every strobe transition. If it reaches its limit it raises one expiry pulse, and that pulse produces a reset of exactly one stretch period. The watchdog is held cleared while the reset is asserted. All intervals are parameters in clock cycles. The reset is available as an active-high output and as an active-low output.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_low_i` is 1 the reset is asserted. Setting it asserts the reset at the first rising clock edge that samples it.
- R2: A low level on `man_rst_n_i` shorter than GLITCH_CYC cycles has no effect on the reset. A low level of GLITCH_CYC cycles or more asserts the reset at the (GLITCH_CYC+3)th edge after it begins.
- R3: While `aux_rst_n_i` is 0 the reset is held. Driving it low asserts the reset at the 3rd edge.
- R4: After the last source releases, the reset deasserts at a fixed edge: the RST_CYC-th edge after `supply_low_i` clears, the (RST_CYC+2)th edge after `aux_rst_n_i` rises, and the (RST_CYC+GLITCH_CYC+2)th edge after `man_rst_n_i` rises.
- R5: The watchdog restarts on both rising and falling strobe transitions. If transitions come less than WD_CYC cycles apart, the watchdog never causes a reset. After the last transition, the reset asserts at the (WD_CYC+4)th edge.
- R6: A reset caused by the watchdog lasts exactly RST_CYC cycles.
- R7: The watchdog is held cleared while the reset is asserted. After a watchdog reset is released with the strobe idle, the next watchdog reset asserts WD_CYC+1 edges later.
- R8: `sys_rst_o` is always the complement of `sys_rst_n_o`.
- R9: While `rst_n` is low the reset is asserted. After `rst_n` rises, the reset deasserts at the RST_CYC-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low_i | input | 1 | Synchronous flag: supply is below its threshold |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| aux_rst_n_i | input | 1 | Auxiliary reset request, active low, asynchronous |
| strobe_i | input | 1 | Watchdog activity strobe, asynchronous |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |

## Verification
The design holds its state in a few counters and flags: the stretch counter, the watchdog counter, the filter counter, and the synchronizer stages. A wrong value in any of them appears at the ports as a release edge or an assertion edge that is off by at least one cycle. The bench therefore counts edges exactly, from each stimulus change to the change at the output. A watchdog that is not cleared during reset, or that does not restart after its own pulse, shifts the gap between pulses away from WD_CYC+1 within one watchdog period. A filter that lets short pulses through produces a reset within GLITCH_CYC+3 cycles, where none is expected.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

   typedef struct packed {
      logic supply;
      logic manual;
      logic aux;
      logic wdog;
   } rst_src_t;

   function automatic int cnt_width(input longint unsigned limit);
      int w;
      w = 1;
      while ((longint'(1) << w) <= limit) w++;
      return w;
   endfunction

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
   parameter int   WIDTH   = 1,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stage1;
   logic [WIDTH-1:0] stage2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= {WIDTH{RST_VAL}};
         stage2 <= {WIDTH{RST_VAL}};
      end else begin
         stage1 <= d_i;
         stage2 <= stage1;
      end
   end

   assign q_o = stage2;

endmodule

// File: rtl/rstsup_deglitch.sv
module rstsup_deglitch #(
   parameter int   FILT_CYC = 4,
   parameter logic INIT     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (FILT_CYC == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_filter
         localparam int CW = rstsup_pkg::cnt_width(FILT_CYC);
         localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

         logic [CW-1:0] run_cnt;
         logic          level;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_cnt <= '0;
               level   <= INIT;
            end else if (d_i == level) begin
               run_cnt <= '0;
            end else if (run_cnt == LAST) begin
               level   <= d_i;
               run_cnt <= '0;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end

         assign q_o = level;
      end
   endgenerate

endmodule

// File: rtl/rstsup_wdog.sv
module rstsup_wdog #(
   parameter int WD_CYC = 100,
   parameter bit EN     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   input  logic clear_i,
   output logic expire_o
);

   generate
      if (!EN) begin : g_off
         assign expire_o = 1'b0;
      end else begin : g_on
         localparam int CW = rstsup_pkg::cnt_width(WD_CYC);
         localparam logic [CW-1:0] LAST = CW'(WD_CYC - 1);

         logic          strobe_d;
         logic          toggled;
         logic [CW-1:0] idle_cnt;
         logic          fire;

         assign toggled = strobe_i ^ strobe_d;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               strobe_d <= 1'b0;
               idle_cnt <= '0;
               fire     <= 1'b0;
            end else begin
               strobe_d <= strobe_i;
               if (clear_i || toggled) begin
                  idle_cnt <= '0;
                  fire     <= 1'b0;
               end else if (idle_cnt == LAST) begin
                  idle_cnt <= '0;
                  fire     <= 1'b1;
               end else begin
                  idle_cnt <= idle_cnt + 1'b1;
                  fire     <= 1'b0;
               end
            end
         end

         assign expire_o = fire;
      end
   endgenerate

endmodule

// File: rtl/rstsup_stretch.sv
module rstsup_stretch #(
   parameter int RST_CYC = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   output logic active_o
);

   localparam int CW = rstsup_pkg::cnt_width(RST_CYC);
   localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

   logic [CW-1:0] tail_cnt;
   logic          active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail_cnt <= '0;
         active   <= 1'b1;
      end else if (hold_i) begin
         tail_cnt <= '0;
         active   <= 1'b1;
      end else if (active) begin
         if (tail_cnt == LAST) begin
            tail_cnt <= '0;
            active   <= 1'b0;
         end else begin
            tail_cnt <= tail_cnt + 1'b1;
         end
      end
   end

   assign active_o = active;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
   parameter int RST_CYC    = 30_000_000,
   parameter int WD_CYC     = 330_000_000,
   parameter int GLITCH_CYC = 20,
   parameter bit WD_EN      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low_i,
   input  logic man_rst_n_i,
   input  logic aux_rst_n_i,
   input  logic strobe_i,
   output logic sys_rst_o,
   output logic sys_rst_n_o
);

   import rstsup_pkg::*;

   generate
      if (RST_CYC < 1) begin : g_bad_rst
         $error("RST_CYC must be at least 1");
      end
      if (WD_EN && WD_CYC < 2) begin : g_bad_wd
         $error("WD_CYC must be at least 2");
      end
      if (GLITCH_CYC < 0) begin : g_bad_glitch
         $error("GLITCH_CYC must not be negative");
      end
   endgenerate

   logic [2:0] async_raw;
   logic [2:0] async_sync;
   logic       man_filt;
   logic       man_act;
   logic       aux_act;
   logic       wd_expire;
   logic       rst_active;
   logic       hold;
   rst_src_t   src;

   assign async_raw = {strobe_i, aux_rst_n_i, man_rst_n_i};

   rstsup_sync #(.WIDTH(2), .RST_VAL(1'b1)) u_sync_req (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (async_raw[1:0]),
      .q_o   (async_sync[1:0])
   );

   rstsup_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_sync_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (async_raw[2]),
      .q_o   (async_sync[2])
   );

   rstsup_deglitch #(.FILT_CYC(GLITCH_CYC), .INIT(1'b1)) u_man_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (async_sync[0]),
      .q_o   (man_filt)
   );

   assign man_act = ~man_filt;
   assign aux_act = ~async_sync[1];

   rstsup_wdog #(.WD_CYC(WD_CYC), .EN(WD_EN)) u_wdog (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (async_sync[2]),
      .clear_i  (rst_active),
      .expire_o (wd_expire)
   );

   assign src.supply = supply_low_i;
   assign src.manual = man_act;
   assign src.aux    = aux_act;
   assign src.wdog   = wd_expire;
   assign hold       = |src;

   rstsup_stretch #(.RST_CYC(RST_CYC)) u_stretch (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_i   (hold),
      .active_o (rst_active)
   );

   assign sys_rst_o   = rst_active;
   assign sys_rst_n_o = ~rst_active;

endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
   parameter int RST_CYC = 40
) (
   input logic clk,
   input logic rst_n,
   input logic supply_low_i,
   input logic man_act,
   input logic aux_act,
   input logic wd_expire,
   input logic hold,
   input logic sys_rst_o,
   input logic sys_rst_n_o
);

   localparam int QW = rstsup_pkg::cnt_width(RST_CYC + 1);
   localparam logic [QW-1:0] QMAX = QW'(RST_CYC + 1);

   logic [QW-1:0] quiet_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             quiet_cnt <= '0;
      else if (hold)          quiet_cnt <= '0;
      else if (quiet_cnt != QMAX) quiet_cnt <= quiet_cnt + 1'b1;
   end

   AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      supply_low_i |=> sys_rst_o); // R1

   AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      man_act |=> sys_rst_o); // R2

   AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      aux_act |=> sys_rst_o); // R3

   AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_o) |-> quiet_cnt == QW'(RST_CYC)); // R4

   AST_WDOG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |=> !wd_expire); // R7

   AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o != sys_rst_n_o); // R8

endmodule

bind rst_supervisor rst_supervisor_chk #(.RST_CYC(RST_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .supply_low_i (supply_low_i),
   .man_act      (man_act),
   .aux_act      (aux_act),
   .wd_expire    (wd_expire),
   .hold         (hold),
   .sys_rst_o    (sys_rst_o),
   .sys_rst_n_o  (sys_rst_n_o)
);

// File: tb/rst_supervisor_bench.sv
`timescale 1ns/1ps
module rst_supervisor_bench;

   localparam int RST_CYC    = 40;
   localparam int WD_CYC     = 100;
   localparam int GLITCH_CYC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_low_i = 1'b0;
   logic man_rst_n_i = 1'b1;
   logic aux_rst_n_i = 1'b1;
   logic strobe_i = 1'b0;
   logic sys_rst_o;
   logic sys_rst_n_o;
   logic kick_en = 1'b0;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   rst_supervisor #(
      .RST_CYC    (RST_CYC),
      .WD_CYC     (WD_CYC),
      .GLITCH_CYC (GLITCH_CYC),
      .WD_EN      (1'b1)
   ) u_rst_supervisor (
      .clk          (clk),
      .rst_n        (rst_n),
      .supply_low_i (supply_low_i),
      .man_rst_n_i  (man_rst_n_i),
      .aux_rst_n_i  (aux_rst_n_i),
      .strobe_i     (strobe_i),
      .sys_rst_o    (sys_rst_o),
      .sys_rst_n_o  (sys_rst_n_o)
   );

   initial begin
      forever begin
         repeat (10) @(negedge clk);
         if (kick_en) strobe_i = ~strobe_i;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic edges_to_release(input int max, output int n);
      n = 0;
      while (n < max) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (sys_rst_n_o) break;
      end
   endtask

   task automatic edges_to_assert(input int max, output int n);
      n = 0;
      while (n < max) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (sys_rst_o) break;
      end
   endtask

   task automatic t_power_on();
      int n;
      repeat (5) @(negedge clk);
      check("R9 reset held during rst_n", int'(sys_rst_o), 1);
      check("R8 complement in reset", int'(sys_rst_n_o), 0);
      rst_n = 1'b1;
      kick_en = 1'b1;
      edges_to_release(RST_CYC + 20, n);
      check("R9 power-on release edge", n, RST_CYC);
      check("R8 complement after release", int'(sys_rst_o), 0);
   endtask

   task automatic t_supply();
      int n;
      supply_low_i = 1'b1;
      edges_to_assert(10, n);
      check("R1 supply assert edge", n, 1);
      repeat (60) @(negedge clk);
      check("R1 held while supply low", int'(sys_rst_o), 1);
      supply_low_i = 1'b0;
      edges_to_release(RST_CYC + 20, n);
      check("R4 release after supply", n, RST_CYC);
   endtask

   task automatic t_aux();
      int n;
      aux_rst_n_i = 1'b0;
      edges_to_assert(10, n);
      check("R3 aux assert edge", n, 3);
      repeat (50) @(negedge clk);
      check("R3 held while aux low", int'(sys_rst_o), 1);
      aux_rst_n_i = 1'b1;
      edges_to_release(RST_CYC + 20, n);
      check("R4 release after aux", n, RST_CYC + 2);
   endtask

   task automatic t_manual();
      int n;
      int seen;
      man_rst_n_i = 1'b0;
      repeat (GLITCH_CYC - 1) @(negedge clk);
      man_rst_n_i = 1'b1;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (sys_rst_o) seen++;
      end
      check("R2 short manual pulse ignored", seen, 0);
      man_rst_n_i = 1'b0;
      edges_to_assert(GLITCH_CYC + 10, n);
      check("R2 manual assert edge", n, GLITCH_CYC + 3);
      repeat (30) @(negedge clk);
      man_rst_n_i = 1'b1;
      edges_to_release(RST_CYC + GLITCH_CYC + 20, n);
      check("R4 release after manual", n, RST_CYC + GLITCH_CYC + 2);
   endtask

   task automatic t_watchdog();
      int n;
      int seen;
      seen = 0;
      for (int i = 0; i < 3 * WD_CYC; i++) begin
         @(negedge clk);
         if (sys_rst_o) seen++;
      end
      check("R5 no reset while strobe active", seen, 0);
      kick_en = 1'b0;
      repeat (4) @(negedge clk);
      strobe_i = ~strobe_i;
      edges_to_assert(WD_CYC + 20, n);
      check("R5 watchdog assert edge", n, WD_CYC + 4);
      edges_to_release(RST_CYC + 20, n);
      check("R6 watchdog pulse width", n, RST_CYC);
      edges_to_assert(WD_CYC + 20, n);
      check("R7 gap to next watchdog pulse", n, WD_CYC + 1);
      kick_en = 1'b1;
      edges_to_release(RST_CYC + 20, n);
      check("R6 second pulse width", n, RST_CYC);
      check("R8 complement after pulse", int'(sys_rst_n_o), 1);
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_power_on();
      repeat (5) @(negedge clk);
      t_supply();
      repeat (5) @(negedge clk);
      t_aux();
      repeat (5) @(negedge clk);
      t_manual();
      repeat (5) @(negedge clk);
      t_watchdog();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule